// File: doc/BRIEF.md
# Interleaved Multibank Memory Crossbar

This block joins four requesting processor ports to a group of word-wide memory banks, two or four of them as chosen by a parameter. Consecutive word addresses are spread over the banks by the low word-address bits. Through the full crossbar, ports that target different banks are all served in the same cycle. Only ports that collide on one bank wait for each other. In that case a round-robin arbiter owned by that bank picks one winner per cycle.

Each port is a valid/ready request channel. `req_valid` offers an access made of an address, a write flag and write data, and `req_ready` is the grant. A transfer happens in every cycle where both are high. `req_ready` may depend on `req_valid` in the same cycle. A requester that sees `req_valid` high with `req_ready` low must keep `req_valid`, `req_write`, `req_addr` and `req_wdata` unchanged until the cycle it is granted. A granted read returns its word one cycle later on that port's response pins. Responses cannot be back-pressured. The bank storage is held inside the block as synchronous single-port RAM arrays.

Top module: `mem_xbar`

## Requirements
- R1: After reset no port shows `rsp_valid`, `req_ready` is low on every idle port, and a lone request to an idle bank is granted in the same cycle it is offered.
- R2: The bank index is `addr[2 +: log2(NBANKS)]`. The word within the bank is the next `log2(BANK_WORDS)` bits above it (bits [9:4] for 4 banks of 64 words). Higher address bits are ignored, so address A and A + 4·NBANKS·BANK_WORDS reach the same word. Consecutive word addresses land in different banks.
- R3: Ports whose requests decode to different banks are all granted in the same cycle. A bank with at least one request grants exactly one of them.
- R4: No two ports are ever granted the same bank in one cycle, and a grant only goes to a port that requests that bank.
- R5: Each bank keeps a pointer, reset to port 0. Priority runs from the pointer upward through the port numbers, wrapping around. After a grant the pointer moves to the winner's number plus one, modulo 4. A port holding a request waits no more than 3 cycles.
- R6: A port that loses arbitration keeps its request unchanged and is served later with the correct result.
- R7: A granted write (`req_write`=1) stores `req_wdata` into the addressed word at the end of the grant cycle. A write never raises `rsp_valid`.
- R8: A granted read (`req_write`=0) raises `rsp_valid` on that port only, in the cycle after the grant, with `rsp_rdata` holding the addressed word.
- R9: A read and a write to the same bank in the same cycle are serialized. The read returns the old word if it wins and the new word if it is granted after the write.
- R10: Address bits [1:0] (byte offset) have no effect on which word is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Request offered, one bit per port |
| req_ready | output | NPORTS | Request granted this cycle, one bit per port |
| req_write | input | NPORTS | 1 = write, 0 = read, one bit per port |
| req_addr | input | NPORTS x AW | Byte address per port |
| req_wdata | input | NPORTS x DW | Write data per port |
| rsp_valid | output | NPORTS | Read data valid, one cycle after a read grant |
| rsp_rdata | output | NPORTS x DW | Read data per port |

## Verification
The assertions assume that every requester obeys the hold rule: once it is refused, its valid, address, write flag and data stay fixed until it is granted. The starvation bound is only meaningful under that assumption. They also assume that NBANKS is 2 or 4. The bench drives all traffic through a batch driver that keeps each refused request and its fields steady and drops a port's valid only after it has seen that port's grant. The driver runs a round-robin and memory model of its own to predict every grant and every returned word.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // byte offset bits below the word address
  localparam int XB_BYTE_OFS = 2;

  // cyclic successor of a port number
  function automatic int xb_next(input int cur, input int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb
  import xbar_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] win;
  logic          any;

  // first requester at or after the pointer, wrapping
  always_comb begin
    gnt = '0;
    win = ptr_q;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      int cand;
      cand = (int'(ptr_q) + k) % N;
      if (!any && req[cand]) begin
        any       = 1'b1;
        gnt[cand] = 1'b1;
        win       = PW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (any) ptr_q <= PW'(xb_next(int'(win), N));
  end

  // cycles each port has waited with a pending, refused request
  logic [N-1:0][PW:0] wait_q;
  always_ff @(posedge clk) begin
    if (!rst_n) wait_q <= '0;
    else begin
      for (int p = 0; p < N; p++)
        wait_q[p] <= (req[p] && !gnt[p]) ? wait_q[p] + 1'b1 : '0;
    end
  end

  AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R4
  AST_ARB_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R4
  AST_ARB_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt)); // R3

  for (genvar p = 0; p < N; p++) begin : g_wait
    AST_RR_NO_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q[p] <= (PW+1)'(N - 1)); // R5
  end
endmodule

// File: rtl/xbar_bank_ram.sv
module xbar_bank_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end
endmodule

// File: rtl/xbar_bank.sv
module xbar_bank #(
  parameter int NP = 4,
  parameter int DW = 32,
  parameter int IW = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          req,
  input  logic [NP-1:0]          wr,
  input  logic [NP-1:0][IW-1:0]  idx,
  input  logic [NP-1:0][DW-1:0]  wdata,
  output logic [NP-1:0]          gnt,
  output logic [DW-1:0]          rdata
);
  localparam int DEPTH = 1 << IW;

  logic          sel_en;
  logic          sel_we;
  logic [IW-1:0] sel_idx;
  logic [DW-1:0] sel_wd;

  xbar_rr_arb #(.N(NP)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .gnt  (gnt)
  );

  // one-hot grant steers the winning port into the RAM
  always_comb begin
    sel_en  = |gnt;
    sel_we  = 1'b0;
    sel_idx = '0;
    sel_wd  = '0;
    for (int p = 0; p < NP; p++) begin
      if (gnt[p]) begin
        sel_we  = sel_we  | wr[p];
        sel_idx = sel_idx | idx[p];
        sel_wd  = sel_wd  | wdata[p];
      end
    end
  end

  xbar_bank_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .en   (sel_en),
    .we   (sel_we),
    .idx  (sel_idx),
    .wdata(sel_wd),
    .rdata(rdata)
  );
endmodule

// File: rtl/mem_xbar.sv
module mem_xbar
  import xbar_pkg::*;
#(
  parameter int NPORTS     = 4,
  parameter int NBANKS     = 4,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int BANK_WORDS = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORTS-1:0]            req_valid,
  output logic [NPORTS-1:0]            req_ready,
  input  logic [NPORTS-1:0]            req_write,
  input  logic [NPORTS-1:0][AW-1:0]    req_addr,
  input  logic [NPORTS-1:0][DW-1:0]    req_wdata,
  output logic [NPORTS-1:0]            rsp_valid,
  output logic [NPORTS-1:0][DW-1:0]    rsp_rdata
);
  localparam int BSEL_W  = $clog2(NBANKS);
  localparam int IDX_W   = $clog2(BANK_WORDS);
  localparam int IDX_LSB = XB_BYTE_OFS + BSEL_W;
  localparam int TOP_LSB = IDX_LSB + IDX_W;

  logic [NPORTS-1:0][BSEL_W-1:0] bsel;
  logic [NPORTS-1:0][IDX_W-1:0]  widx;
  logic [NPORTS-1:0]             addr_unused;

  logic [NBANKS-1:0][NPORTS-1:0] bank_req;
  logic [NBANKS-1:0][NPORTS-1:0] bank_gnt;
  logic [NBANKS-1:0][DW-1:0]     bank_rd;

  logic [NPORTS-1:0]             rsp_valid_q;
  logic [NPORTS-1:0][BSEL_W-1:0] rsp_bank_q;

  // address split: bank from low word bits, word index above it
  for (genvar p = 0; p < NPORTS; p++) begin : g_dec
    assign bsel[p]        = req_addr[p][XB_BYTE_OFS +: BSEL_W];
    assign widx[p]        = req_addr[p][IDX_LSB +: IDX_W];
    assign addr_unused[p] = ^{req_addr[p][AW-1:TOP_LSB], req_addr[p][XB_BYTE_OFS-1:0]};
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    for (genvar p = 0; p < NPORTS; p++) begin : g_hit
      assign bank_req[b][p] = req_valid[p] && (bsel[p] == BSEL_W'(b));
    end

    xbar_bank #(.NP(NPORTS), .DW(DW), .IW(IDX_W)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (bank_req[b]),
      .wr   (req_write),
      .idx  (widx),
      .wdata(req_wdata),
      .gnt  (bank_gnt[b]),
      .rdata(bank_rd[b])
    );

    AST_BANK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_ready & bank_req[b]) <= 1); // R4
  end

  // a port is granted when any bank picks it
  always_comb begin
    req_ready = '0;
    for (int b = 0; b < NBANKS; b++) req_ready = req_ready | bank_gnt[b];
  end

  // response path: remember which bank serves each granted read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= '0;
      rsp_bank_q  <= '0;
    end else begin
      rsp_valid_q <= req_valid & req_ready & ~req_write;
      rsp_bank_q  <= bsel;
    end
  end

  assign rsp_valid = rsp_valid_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_rsp
    assign rsp_rdata[p] = bank_rd[rsp_bank_q[p]];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && !req_ready[p]) |=> (req_valid[p] && $stable(req_addr[p])
        && $stable(req_write[p]) && $stable(req_wdata[p]))); // R6
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_rsp_chk
    logic [NPORTS-1:0] rsp_from_b;
    for (genvar p = 0; p < NPORTS; p++) begin : g_m
      assign rsp_from_b[p] = rsp_valid[p] && (rsp_bank_q[p] == BSEL_W'(b));
    end
    AST_RSP_ONE_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rsp_from_b) <= 1); // R8
  end
endmodule

// File: tb/tb_mem_xbar.sv
`timescale 1ns/1ps
module tb_mem_xbar;
  localparam int NP  = 4;
  localparam int NB  = 4;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int BWD = 64;
  localparam int BSW = 2;
  localparam int IXW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]         req_valid = '0;
  logic [NP-1:0]         req_ready;
  logic [NP-1:0]         req_write = '0;
  logic [NP-1:0][AW-1:0] req_addr = '0;
  logic [NP-1:0][DW-1:0] req_wdata = '0;
  logic [NP-1:0]         rsp_valid;
  logic [NP-1:0][DW-1:0] rsp_rdata;

  always #2 clk = ~clk;

  mem_xbar #(.NPORTS(NP), .NBANKS(NB), .AW(AW), .DW(DW), .BANK_WORDS(BWD)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [DW-1:0] mem_m  [NB][BWD];
  bit            known_m[NB][BWD];
  int            ptr_m  [NB];
  logic [NP-1:0] got_ready;

  logic [NP-1:0]         b_w;
  logic [AW-1:0]         b_addr [NP];
  logic [DW-1:0]         b_wd   [NP];

  function automatic int bank_of(logic [AW-1:0] a);
    return int'(a[2 +: BSW]);
  endfunction
  function automatic int idx_of(logic [AW-1:0] a);
    return int'(a[2+BSW +: IXW]);
  endfunction

  task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // one cycle: predict grants from the model, then check responses
  task automatic step();
    logic [NP-1:0] exp_rdy, exp_rv;
    logic [DW-1:0] exp_rd [NP];
    exp_rdy = '0;
    exp_rv  = '0;
    for (int p = 0; p < NP; p++) exp_rd[p] = '0;
    for (int b = 0; b < NB; b++) begin
      bit found;
      found = 0;
      for (int k = 0; k < NP; k++) begin
        int c;
        c = (ptr_m[b] + k) % NP;
        if (!found && req_valid[c] && bank_of(req_addr[c]) == b) begin
          found = 1;
          exp_rdy[c] = 1'b1;
          ptr_m[b] = (c + 1) % NP;
        end
      end
    end
    #1;
    got_ready = req_ready;
    check(req_ready == exp_rdy, "R5", "grant vector", 32'(req_ready), 32'(exp_rdy));
    for (int p = 0; p < NP; p++) begin
      if (exp_rdy[p]) begin
        int b, i;
        b = bank_of(req_addr[p]);
        i = idx_of(req_addr[p]);
        if (req_write[p]) begin
          mem_m[b][i]   = req_wdata[p];
          known_m[b][i] = 1;
        end else begin
          exp_rv[p] = 1'b1;
          exp_rd[p] = known_m[b][i] ? mem_m[b][i] : 'x;
        end
      end
    end
    @(negedge clk);
    check(rsp_valid == exp_rv, "R8", "response strobe", 32'(rsp_valid), 32'(exp_rv));
    for (int p = 0; p < NP; p++)
      if (exp_rv[p] && !$isunknown(exp_rd[p]))
        check(rsp_rdata[p] == exp_rd[p], "R8", $sformatf("read data port %0d", p),
              rsp_rdata[p], exp_rd[p]);
  endtask

  // hold each request steady until granted; returns cycles used
  task automatic run_batch(input logic [NP-1:0] v, output int cycles);
    logic [NP-1:0] pend;
    pend = v;
    cycles = 0;
    for (int p = 0; p < NP; p++) begin
      req_write[p] = b_w[p];
      req_addr[p]  = b_addr[p];
      req_wdata[p] = b_wd[p];
    end
    while (pend != 0 && cycles < 20) begin
      req_valid = pend;
      step();
      pend = pend & ~got_ready;
      cycles++;
    end
    req_valid = '0;
  endtask

  task automatic single(input int p, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output int cycles);
    b_w[p] = w; b_addr[p] = a; b_wd[p] = d;
    run_batch(NP'(1) << p, cycles);
  endtask

  task automatic t_reset();
    int cyc;
    check(rsp_valid == '0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    #1;
    check(req_ready == '0, "R1", "ready idle after reset", 32'(req_ready), 0);
    @(negedge clk);
    single(0, 1'b1, 32'h0, 32'hA5A5_0000, cyc);
    check(cyc == 1, "R1", "lone request cycles", cyc, 1);
  endtask

  task automatic t_parallel();
    int cyc;
    for (int p = 0; p < NP; p++) begin
      b_w[p] = 1'b1; b_addr[p] = 32'h100 + 32'(4*p); b_wd[p] = 32'h1111_0000 + 32'(p);
    end
    run_batch('1, cyc);
    check(cyc == 1, "R3", "four writes to four banks", cyc, 1);
    check(rsp_valid == '0, "R7", "no strobe for writes", 32'(rsp_valid), 0);
    for (int p = 0; p < NP; p++) begin
      b_w[p] = 1'b0; b_addr[p] = 32'h10C - 32'(4*p);
    end
    run_batch('1, cyc);
    check(cyc == 1, "R3", "four reads to four banks", cyc, 1);
  endtask

  task automatic t_conflict();
    int cyc;
    for (int k = 1; k < 4; k++) single(0, 1'b1, 32'h100 + 32'(16*k), 32'h2222_0000 + 32'(k), cyc);
    for (int p = 0; p < NP; p++) begin
      b_w[p] = 1'b0; b_addr[p] = 32'h100 + 32'(16*p);
    end
    run_batch('1, cyc);
    check(cyc == 4, "R5", "four reads to one bank serialize", cyc, 4);
    check(cyc < 20, "R6", "refused ports eventually served", cyc, 4);
    // second round starts from a moved pointer
    for (int p = 0; p < NP; p++) b_addr[p] = 32'h130 - 32'(16*p);
    run_batch(4'b1010, cyc);
    check(cyc == 2, "R5", "two-way collision cycles", cyc, 2);
  endtask

  task automatic t_rw_same();
    int cyc;
    single(1, 1'b1, 32'h140, 32'hAAAA_0001, cyc);
    b_w[1] = 1'b1; b_addr[1] = 32'h140; b_wd[1] = 32'hBBBB_0002;
    b_w[2] = 1'b0; b_addr[2] = 32'h140;
    run_batch(4'b0110, cyc);
    check(cyc == 2, "R9", "read and write same bank serialize", cyc, 2);
    single(3, 1'b0, 32'h140, 0, cyc);
    @(negedge clk);
    single(2, 1'b0, 32'h140, 0, cyc);
    check(mem_m[bank_of(32'h140)][idx_of(32'h140)] == 32'hBBBB_0002, "R9",
          "model holds new word", mem_m[0][20], 32'hBBBB_0002);
  endtask

  task automatic t_mapping();
    int cyc;
    for (int k = 0; k < 4; k++) single(3, 1'b1, 32'h200 + 32'(4*k), 32'h3333_0000 + 32'(k), cyc);
    // alias one bank-array span higher reaches the same word
    single(0, 1'b0, 32'h200 + 32'(4*NB*BWD), 0, cyc);
    check(cyc == 1, "R2", "alias read granted", cyc, 1);
    // byte offset ignored
    single(1, 1'b0, 32'h207, 0, cyc);
    check(cyc == 1, "R10", "byte-offset read granted", cyc, 1);
    b_w[0] = 1'b0; b_addr[0] = 32'h200;
    b_w[1] = 1'b0; b_addr[1] = 32'h204;
    run_batch(4'b0011, cyc);
    check(cyc == 1, "R2", "consecutive words in different banks", cyc, 1);
    b_addr[1] = 32'h210;
    run_batch(4'b0011, cyc);
    check(cyc == 2, "R2", "words 4 apart share a bank", cyc, 2);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      ptr_m[b] = 0;
      for (int i = 0; i < BWD; i++) known_m[b][i] = 0;
    end
    for (int p = 0; p < NP; p++) begin
      b_addr[p] = '0; b_wd[p] = '0;
    end
    b_w = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_parallel();
    t_conflict();
    t_rw_same();
    t_mapping();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule